// File: doc/BRIEF.md
# Multi-Channel Interval Timer with APB Access

This peripheral provides a configurable number of independent timer channels behind an APB slave port. Each channel holds a control word, a reload value and a down-counter. The control word's mode field splits the channel into one 32-bit timer, two 16-bit timers or four 8-bit timers. Every sub-timer has its own run bit, its own sticky expiry flag and its own interrupt mask bit. Run bits, mask bits and flags are grouped in nibbles, one nibble per channel.

A running sub-timer counts down once per step. A step is either every APB clock cycle or one rising edge of that channel's external tick input. The tick input is resynchronised to the APB clock before its edges are detected. When a sub-timer is stepped at zero, it reloads its slice of the reload register and raises its flag, so it fires periodically until software clears its run bit. A single interrupt output is high whenever a raised flag is unmasked.

Software sets up a channel by writing the control and reload words. It then sets the run bits and services the interrupt by writing ones to the flags it has handled.

Top module: `apb_interval_timer`

## Requirements
- R1: After reset, every control, reload, counter, run, mask and flag register reads zero and `irq` is low. The identity word (offset 0x00) reads 0x0A170100, and the configuration word (offset 0x10) reads the channel count.
- R2: Channel c decodes its control word at 0x20+16c, its reload word at 0x24+16c and its read-only counter at 0x28+16c. Run bits sit at 0x1C, mask bits at 0x14 and flags at 0x18. Sub-timer i of channel c owns bit 4c+i in each of those three registers.
- R3: Control bits [2:0] = 1 gives one 32-bit timer that uses run/flag bit 4c. A running timer decrements by one per step, so it fires every reload+1 steps.
- R4: Control bits [2:0] = 2 gives two 16-bit timers. Timer i uses bits [16i+15:16i] of the reload and counter words, and bit 4c+i. The two timers count and fire independently.
- R5: Control bits [2:0] = 3 gives four 8-bit timers. Timer i uses bits [8i+7:8i] and bit 4c+i, and the four count and fire independently.
- R6: Any other value of control bits [2:0] leaves the channel idle, and its counter holds its value whatever the run bits are.
- R7: Control bit 3 = 1 steps the channel on every APB clock cycle. Control bit 3 = 0 steps it once per rising edge of its `ext_tick` bit, after a two-flop synchroniser.
- R8: While a run bit is clear, the counter slice of that sub-timer holds its value. When the run bit changes from 0 to 1, the slice loads the current reload slice in the following cycle.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as the clearing write leaves the flag set. A raised flag stays set until it is cleared.
- R10: `irq` is high exactly when some flag bit and its matching mask bit are both set.
- R11: Writes to the identity and configuration words have no effect. Reads of any unmapped offset, including the unused fourth word of each channel, return zero.
- R12: At expiry the slice reloads and keeps running, so the sub-timer fires periodically with its flag set on each expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready (zero wait states) |
| ext_tick | input | NUM_CH | Per-channel external step input |
| irq | output | 1 | Combined masked interrupt |

## Verification
The timer is run in each split mode with reload values chosen so that the slices expire at different rates. This exposes a slice that borrows from or reloads with its neighbour, and a flag bit routed to the wrong position. An idle mode with the run bit set shows the decoder treats undefined modes as stopped. A slowly toggling external tick is set against APB-clocked stepping to show that only synchronised rising edges count. Stop, reload rewrite and restart, along with writes of zero and of one to the flags, tell a re-arm from a free run and a proper clear from a lost one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned LANES    = 4;
    localparam int unsigned CNT_W    = 32;
    localparam int unsigned CTRL_W   = 4;

    localparam logic [2:0] MODE_W32 = 3'd1;
    localparam logic [2:0] MODE_W16 = 3'd2;
    localparam logic [2:0] MODE_W8  = 3'd3;

    localparam int unsigned OFF_ID     = 32'h00;
    localparam int unsigned OFF_CFG    = 32'h10;
    localparam int unsigned OFF_MASK   = 32'h14;
    localparam int unsigned OFF_FLAG   = 32'h18;
    localparam int unsigned OFF_RUN    = 32'h1C;
    localparam int unsigned CH_BASE    = 32'h20;
    localparam int unsigned CH_STRIDE  = 32'h10;
    localparam int unsigned CH_CTRL    = 32'h0;
    localparam int unsigned CH_RELOAD  = 32'h4;
    localparam int unsigned CH_COUNT   = 32'h8;

endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_pulse
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = tick_in;
        s_d.sync = s_q.meta;
        s_d.last = s_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // one pulse per synchronised rising edge
    assign tick_pulse = s_q.sync & ~s_q.last;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic             step,
    input  logic [LANES-1:0] run,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic [LANES-1:0] expire
);

    localparam int unsigned HALF_W = CNT_W / 2;
    localparam int unsigned BYTE_W = CNT_W / LANES;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [LANES-1:0] run_prev;
    } chan_t;

    chan_t c_d, c_q;
    logic [LANES-1:0] arm;

    assign arm = run & ~c_q.run_prev;

    always_comb begin
        c_d          = c_q;
        c_d.run_prev = run;
        expire       = '0;
        unique case (mode)
            MODE_W32: begin
                if (arm[0]) begin
                    c_d.cnt = reload;
                end else if (run[0] && step) begin
                    if (c_q.cnt == '0) begin
                        c_d.cnt   = reload;
                        expire[0] = 1'b1;
                    end else begin
                        c_d.cnt = c_q.cnt - 1'b1;
                    end
                end
            end
            MODE_W16: begin
                for (int i = 0; i < 2; i++) begin
                    if (arm[i]) begin
                        c_d.cnt[i*HALF_W +: HALF_W] = reload[i*HALF_W +: HALF_W];
                    end else if (run[i] && step) begin
                        if (c_q.cnt[i*HALF_W +: HALF_W] == '0) begin
                            c_d.cnt[i*HALF_W +: HALF_W] = reload[i*HALF_W +: HALF_W];
                            expire[i] = 1'b1;
                        end else begin
                            c_d.cnt[i*HALF_W +: HALF_W] =
                                c_q.cnt[i*HALF_W +: HALF_W] - 1'b1;
                        end
                    end
                end
            end
            MODE_W8: begin
                for (int i = 0; i < LANES; i++) begin
                    if (arm[i]) begin
                        c_d.cnt[i*BYTE_W +: BYTE_W] = reload[i*BYTE_W +: BYTE_W];
                    end else if (run[i] && step) begin
                        if (c_q.cnt[i*BYTE_W +: BYTE_W] == '0) begin
                            c_d.cnt[i*BYTE_W +: BYTE_W] = reload[i*BYTE_W +: BYTE_W];
                            expire[i] = 1'b1;
                        end else begin
                            c_d.cnt[i*BYTE_W +: BYTE_W] =
                                c_q.cnt[i*BYTE_W +: BYTE_W] - 1'b1;
                        end
                    end
                end
            end
            default: begin
                c_d.cnt = c_q.cnt;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count = c_q.cnt;

endmodule

// File: rtl/apb_interval_timer.sv
module apb_interval_timer
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned ADDR_W   = 12,
    parameter logic [31:0] ID_VALUE = 32'h0A17_0100
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    input  logic [NUM_CH-1:0] ext_tick,
    output logic              irq
);

    localparam int unsigned NB = LANES * NUM_CH;

    typedef struct packed {
        logic [NUM_CH-1:0][CTRL_W-1:0] ctrl;
        logic [NUM_CH-1:0][CNT_W-1:0]  reload;
        logic [NB-1:0]                 mask;
        logic [NB-1:0]                 run;
        logic [NB-1:0]                 flag;
    } regs_t;

    regs_t r_d, r_q;

    logic                          wr_en;
    logic                          wr_flag;
    logic [NB-1:0]                 exp_all;
    logic [NB-1:0]                 flag_w;
    logic [NB-1:0]                 run_w;
    logic [NUM_CH-1:0]             ext_pulse;
    logic [NUM_CH-1:0]             step;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all;
    logic [31:0]                   rdata;

    function automatic logic [ADDR_W-1:0] at(input int unsigned off);
        return ADDR_W'(off);
    endfunction

    function automatic logic [ADDR_W-1:0] ch_at(input int unsigned c,
                                                 input int unsigned off);
        return ADDR_W'(CH_BASE + CH_STRIDE * c + off);
    endfunction

    assign wr_en   = psel & penable & pwrite;
    assign wr_flag = wr_en & (paddr == at(OFF_FLAG));

    // ---------------- channels ----------------
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmr_tick_sync i_sync (
            .clk        (pclk),
            .rst_n      (presetn),
            .tick_in    (ext_tick[c]),
            .tick_pulse (ext_pulse[c])
        );

        assign step[c] = r_q.ctrl[c][3] | ext_pulse[c];

        tmr_channel i_chan (
            .clk    (pclk),
            .rst_n  (presetn),
            .mode   (r_q.ctrl[c][2:0]),
            .step   (step[c]),
            .run    (r_q.run[c*LANES +: LANES]),
            .reload (r_q.reload[c]),
            .count  (cnt_all[c]),
            .expire (exp_all[c*LANES +: LANES])
        );
    end

    // ---------------- register next state ----------------
    always_comb begin
        r_d = r_q;
        if (wr_flag) begin
            r_d.flag = (r_q.flag & ~pwdata[NB-1:0]) | exp_all;
        end else begin
            r_d.flag = r_q.flag | exp_all;
        end
        if (wr_en && paddr == at(OFF_MASK)) begin
            r_d.mask = pwdata[NB-1:0];
        end
        if (wr_en && paddr == at(OFF_RUN)) begin
            r_d.run = pwdata[NB-1:0];
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (wr_en && paddr == ch_at(c, CH_CTRL)) begin
                r_d.ctrl[c] = pwdata[CTRL_W-1:0];
            end
            if (wr_en && paddr == ch_at(c, CH_RELOAD)) begin
                r_d.reload[c] = pwdata;
            end
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        rdata = '0;
        if (paddr == at(OFF_ID)) begin
            rdata = ID_VALUE;
        end else if (paddr == at(OFF_CFG)) begin
            rdata = 32'(NUM_CH);
        end else if (paddr == at(OFF_MASK)) begin
            rdata = 32'(r_q.mask);
        end else if (paddr == at(OFF_FLAG)) begin
            rdata = 32'(r_q.flag);
        end else if (paddr == at(OFF_RUN)) begin
            rdata = 32'(r_q.run);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (paddr == ch_at(c, CH_CTRL)) begin
                rdata = 32'(r_q.ctrl[c]);
            end else if (paddr == ch_at(c, CH_RELOAD)) begin
                rdata = r_q.reload[c];
            end else if (paddr == ch_at(c, CH_COUNT)) begin
                rdata = cnt_all[c];
            end
        end
    end

    assign flag_w = r_q.flag;
    assign run_w  = r_q.run;
    assign prdata = rdata;
    assign pready = 1'b1;
    assign irq    = |(r_q.flag & r_q.mask);

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int unsigned NB = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_flag,
    input logic [NB-1:0] wdata,
    input logic [NB-1:0] flag,
    input logic [NB-1:0] expire,
    input logic [3:0]    run0,
    input logic [31:0]   cnt0,
    input logic          irq
);

    // R9: a written one clears the flag unless an expiry hits the same cycle
    p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flag |=> ((flag & $past(wdata & ~expire)) == '0));

    // R9: without a flag write, raised flags never drop
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flag |=> ((flag & $past(flag)) == $past(flag)));

    // R12: every expiry leaves its flag set
    p_expire_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (expire != '0) |=> ((flag & $past(expire)) == $past(expire)));

    // R8: channel 0 counter frozen while all its run bits are clear
    p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run0 == 4'b0) |=> $stable(cnt0));

    // R10: no raised flag, no interrupt
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag == '0) |-> !irq);

endmodule

bind apb_interval_timer tmr_checker #(.NB(NB)) i_tmr_checker (
    .clk     (pclk),
    .rst_n   (presetn),
    .wr_flag (wr_flag),
    .wdata   (pwdata[NB-1:0]),
    .flag    (flag_w),
    .expire  (exp_all),
    .run0    (run_w[3:0]),
    .cnt0    (cnt_all[0]),
    .irq     (irq)
);

// File: tb/test_apb_interval_timer.sv
module test_apb_interval_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam logic [31:0] IDV = 32'h0A17_0100;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [NCH-1:0] ext_tick = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    apb_interval_timer #(.NUM_CH(NCH)) i_apb_interval_timer (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .ext_tick(ext_tick), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [3:0]  m_ctrl [NCH];
    logic [31:0] m_rel  [NCH];
    logic [31:0] m_cnt  [NCH];
    logic [15:0] m_run, m_prev, m_mask, m_flag;
    logic [NCH-1:0] m_s1, m_s2, m_s3;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_ctrl[c] = 0; m_rel[c] = 0; m_cnt[c] = 0;
            end
            m_run = 0; m_prev = 0; m_mask = 0; m_flag = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            logic [15:0] fired;
            logic [31:0] ncnt [NCH];
            fired = 0;
            for (int c = 0; c < NCH; c++) begin
                int lanes, w;
                bit stp;
                longint unsigned mask, sl, rl;
                ncnt[c] = m_cnt[c];
                stp = m_ctrl[c][3] ? 1'b1 : (m_s2[c] & ~m_s3[c]);
                case (m_ctrl[c][2:0])
                    3'd1: lanes = 1;
                    3'd2: lanes = 2;
                    3'd3: lanes = 4;
                    default: lanes = 0;
                endcase
                w = (lanes == 0) ? 32 : 32 / lanes;
                mask = (64'd1 << w) - 1;
                for (int i = 0; i < lanes; i++) begin
                    int b;
                    b  = 4*c + i;
                    sl = (longint'(m_cnt[c]) >> (i*w)) & mask;
                    rl = (longint'(m_rel[c]) >> (i*w)) & mask;
                    if (m_run[b] && !m_prev[b]) sl = rl;
                    else if (m_run[b] && stp) begin
                        if (sl == 0) begin sl = rl; fired[b] = 1; end
                        else sl = sl - 1;
                    end
                    ncnt[c] = 32'((longint'(ncnt[c]) & ~(mask << (i*w))) | (sl << (i*w)));
                end
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_tick;
            m_prev = m_run;
            for (int c = 0; c < NCH; c++) m_cnt[c] = ncnt[c];
            if (psel && penable && pwrite) begin
                if (paddr == 12'h18) m_flag = m_flag & ~pwdata[15:0];
                if (paddr == 12'h14) m_mask = pwdata[15:0];
                if (paddr == 12'h1C) m_run  = pwdata[15:0];
                for (int c = 0; c < NCH; c++) begin
                    if (paddr == 12'(32'h20 + 16*c)) m_ctrl[c] = pwdata[3:0];
                    if (paddr == 12'(32'h24 + 16*c)) m_rel[c]  = pwdata;
                end
            end
            m_flag = m_flag | fired;
        end
    end

    function automatic logic [31:0] m_read(input logic [11:0] a);
        if (a == 12'h00) return IDV;
        if (a == 12'h10) return NCH;
        if (a == 12'h14) return {16'h0, m_mask};
        if (a == 12'h18) return {16'h0, m_flag};
        if (a == 12'h1C) return {16'h0, m_run};
        for (int c = 0; c < NCH; c++) begin
            if (a == 12'(32'h20 + 16*c)) return {28'h0, m_ctrl[c]};
            if (a == 12'(32'h24 + 16*c)) return m_rel[c];
            if (a == 12'(32'h28 + 16*c)) return m_cnt[c];
        end
        return 32'h0;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) check("R10 irq vs model", {31'h0, irq}, {31'h0, |(m_flag & m_mask)});
    end

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, input string req, output logic [31:0] v);
        @(negedge clk);
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk);
        penable = 1;
        #1;
        v = prdata;
        check(req, prdata, m_read(a));
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v, v2;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state and fixed words
        apb_rd(12'h00, "R1 id", v);        check("R1 id literal", v, 32'h0A17_0100);
        apb_rd(12'h10, "R1 cfg", v);       check("R1 cfg literal", v, 32'd4);
        apb_rd(12'h14, "R1 mask", v);
        apb_rd(12'h18, "R1 flag", v);
        apb_rd(12'h1C, "R1 run", v);
        for (int c = 0; c < NCH; c++) begin
            apb_rd(12'(32'h20 + 16*c), "R1 ctrl", v);
            apb_rd(12'(32'h28 + 16*c), "R1 count", v);
        end

        // R11 read-only words and unmapped holes
        apb_wr(12'h00, 32'hFFFF_FFFF);
        apb_wr(12'h10, 32'h1234_5678);
        apb_rd(12'h00, "R11 id after write", v);  check("R11 id literal", v, 32'h0A17_0100);
        apb_rd(12'h10, "R11 cfg after write", v); check("R11 cfg literal", v, 32'd4);
        apb_wr(12'h04, 32'hDEAD_BEEF);
        apb_rd(12'h04, "R11 hole 0x04", v);       check("R11 hole literal", v, 32'h0);
        apb_rd(12'h2C, "R11 hole 0x2C", v);
        apb_rd(12'h60, "R11 beyond channels", v); check("R11 beyond literal", v, 32'h0);

        // R2 R3 R12 channel 0, one 32-bit timer, APB clock
        apb_wr(12'h20, 32'h9);
        apb_wr(12'h24, 32'd5);
        apb_rd(12'h24, "R2 reload ch0", v);
        apb_wr(12'h14, 32'h0001);
        apb_wr(12'h1C, 32'h0001);
        for (int k = 0; k < 8; k++) apb_rd(12'h28, "R3 count ch0", v);
        apb_rd(12'h18, "R12 flag ch0", v);
        check("R12 flag bit0 literal", v & 32'h1, 32'h1);

        // R9 write zero keeps, write one clears
        apb_wr(12'h18, 32'h0);
        apb_rd(12'h18, "R9 write zero", v);
        apb_wr(12'h1C, 32'h0);
        apb_wr(12'h18, 32'h1);
        apb_rd(12'h18, "R9 write one", v);
        check("R9 cleared literal", v & 32'h1, 32'h0);

        // R8 stopped counter holds, restart reloads new value
        apb_rd(12'h28, "R8 stopped a", v);
        idle(5);
        apb_rd(12'h28, "R8 stopped b", v2);
        check("R8 hold literal", v2, v);
        apb_wr(12'h24, 32'd40);
        apb_wr(12'h1C, 32'h0001);
        apb_rd(12'h28, "R8 restart", v);
        for (int k = 0; k < 4; k++) apb_rd(12'h28, "R8 running", v);
        apb_wr(12'h1C, 32'h0);
        apb_wr(12'h18, 32'hFFFF);

        // R4 channel 1, two 16-bit timers with unequal reloads
        apb_wr(12'h30, 32'hA);
        apb_wr(12'h34, 32'h0003_0002);
        apb_wr(12'h14, 32'h0020);
        apb_wr(12'h1C, 32'h0030);
        for (int k = 0; k < 10; k++) begin
            apb_rd(12'h38, "R4 count ch1", v);
            apb_rd(12'h18, "R4 flags ch1", v);
            if (k == 5) apb_wr(12'h18, 32'h0010);
        end
        apb_wr(12'h1C, 32'h0);
        apb_wr(12'h18, 32'hFFFF);

        // R5 channel 2, four 8-bit timers
        apb_wr(12'h40, 32'hB);
        apb_wr(12'h44, 32'h0403_0100);
        apb_wr(12'h14, 32'h0F00);
        apb_wr(12'h1C, 32'h0F00);
        for (int k = 0; k < 10; k++) begin
            apb_rd(12'h48, "R5 count ch2", v);
            apb_rd(12'h18, "R5 flags ch2", v);
        end
        apb_wr(12'h1C, 32'h0);
        apb_wr(12'h18, 32'hFFFF);
        apb_wr(12'h14, 32'h0);

        // R6 undefined modes stay idle
        apb_wr(12'h50, 32'h8);
        apb_wr(12'h54, 32'd7);
        apb_wr(12'h1C, 32'h1000);
        apb_rd(12'h58, "R6 idle mode0 a", v);
        idle(6);
        apb_rd(12'h58, "R6 idle mode0 b", v2);
        check("R6 hold literal", v2, 32'h0);
        apb_wr(12'h50, 32'hD);
        idle(6);
        apb_rd(12'h58, "R6 idle mode5", v);
        check("R6 mode5 literal", v, 32'h0);
        apb_wr(12'h1C, 32'h0);

        // R7 channel 3 stepped by slow external tick
        apb_wr(12'h50, 32'h1);
        apb_wr(12'h54, 32'd3);
        apb_wr(12'h14, 32'h1000);
        apb_wr(12'h1C, 32'h1000);
        for (int k = 0; k < 12; k++) begin
            ext_tick[3] = ~ext_tick[3];
            apb_rd(12'h58, "R7 ext count", v);
            apb_rd(12'h18, "R7 ext flags", v);
        end
        ext_tick[3] = 0;
        apb_wr(12'h18, 32'h1000);
        apb_rd(12'h18, "R10 after clear", v);

        idle(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule